// File: doc/BRIEF.md
# GPIO Pin Function and Output Register Bank

This block holds the pin configuration and output state for a bank of general-purpose pins (54 by default). Each pin owns a 3-bit function code that makes it a GPIO input, a GPIO output, or hands the pad to one of six alternate peripheral functions. The function codes sit ten to a 32-bit register. The output latches never change through a read-modify-write. Software raises latch bits through a write-one-to-set register and lowers them through a separate write-one-to-clear register. A read-only level register returns the synchronized state of the pad inputs.

Software reaches the block over a simple 32-bit register bus: byte address, write enable, write data, and combinational read data. Pin-facing outputs give a per-pin output enable, the output latch value, and an alternate-function enable and index that an outside pad mux decodes.

Top module: `gpio_pinfunc_bank`

## Requirements
- R1: Pin p's function code is the 3-bit field at bits (p%10)*3 and up of the function register at byte address 4*(p/10), starting at 0x00. The field is written by a bus write and read back unchanged.
- R2: Bits 31:30 of every function register read as zero. Fields for pins that do not exist read as zero: in the last function register (0x14), only bits 11:0 are live.
- R3: A write to the set registers (0x1C for pins 0-31, 0x20 for pins 32-53) raises the latch of every pin whose bit is 1 on the next clock edge. Bits at 0 leave their latches unchanged.
- R4: A write to the clear registers (0x28 for pins 0-31, 0x2C for pins 32-53) lowers the latch of every pin whose bit is 1 on the next clock edge. Bits at 0 leave their latches unchanged.
- R5: The set and clear registers read as zero. The latch state appears only on `pad_out`.
- R6: The level registers (0x34 for pins 0-31, 0x38 for pins 32-53) return the pad inputs through a two-flop synchronizer. A change on `pad_in` becomes readable after the second rising edge. Bits 31:22 of 0x38 read as zero.
- R7: `pad_oe` for a pin is 1 exactly when its function code is 1.
- R8: Codes 2 to 7 set `alt_en`, and `alt_idx` (3 bits per pin, pin p at bits p*3+2:p*3) gives the alternate number: code 4→0, 5→1, 6→2, 7→3, 3→4, 2→5. Codes 0 and 1 give `alt_en`=0 and `alt_idx`=0.
- R9: After reset, every function code is 0 and every output latch is 0. As a result, `pad_oe`, `pad_out` and `alt_en` are all 0.
- R10: Addresses outside the function, set, clear and level words (for example 0x18, 0x24, 0x30, 0x3C) read as zero. Writes to them, and writes to the level registers, change no state.
- R11: `bus_rdata` reflects the state before the clock edge. A read of an address during the cycle that writes it returns the old contents, and the new contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 54 | Asynchronous pad input levels |
| pad_oe | output | 54 | Per-pin output driver enable |
| pad_out | output | 54 | Per-pin output latch value |
| alt_en | output | 54 | Per-pin alternate-function ownership of the pad |
| alt_idx | output | 162 | Per-pin alternate number, 3 bits per pin |

## Verification
Two things can fall in one cycle: a bus write to a register, and a read of that same address, because the read data is combinational from state while the write lands at the edge. The bench makes such accesses at many addresses and samples `bus_rdata` just before the edge. A behavioural model, updated only after the edge, judges it, so old contents are expected. A pad input edge arriving while the level register is being read is the second coincidence. The model delays `pad_in` through its own two-stage history and compares the read value on every cycle.

// File: rtl/gpio_pf_pkg.sv
package gpio_pf_pkg;

    localparam int unsigned FN_W          = 3;
    localparam int unsigned PINS_PER_FSEL = 10;
    localparam int unsigned BUS_W         = 32;

    // Word indices (byte address / 4) of the register groups.
    localparam int unsigned SET_WORD = 7;   // 0x1C
    localparam int unsigned CLR_WORD = 10;  // 0x28
    localparam int unsigned LVL_WORD = 13;  // 0x34

    typedef enum logic [FN_W-1:0] {
        FN_INPUT  = 3'd0,
        FN_OUTPUT = 3'd1,
        FN_ALT5   = 3'd2,
        FN_ALT4   = 3'd3,
        FN_ALT0   = 3'd4,
        FN_ALT1   = 3'd5,
        FN_ALT2   = 3'd6,
        FN_ALT3   = 3'd7
    } pin_fn_e;

    typedef struct packed {
        logic            en;
        logic [FN_W-1:0] idx;
    } alt_sel_t;

    function automatic alt_sel_t decode_alt(input logic [FN_W-1:0] code);
        alt_sel_t r;
        r.en  = 1'b1;
        r.idx = '0;
        case (pin_fn_e'(code))
            FN_ALT0: r.idx = 3'd0;
            FN_ALT1: r.idx = 3'd1;
            FN_ALT2: r.idx = 3'd2;
            FN_ALT3: r.idx = 3'd3;
            FN_ALT4: r.idx = 3'd4;
            FN_ALT5: r.idx = 3'd5;
            default: r.en  = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
    import gpio_pf_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned WIDX_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WIDX_W-1:0]        word,
    input  logic [BUS_W-1:0]         wr_data,
    output logic [BUS_W-1:0]         rd_data,
    output logic [NUM_PINS*FN_W-1:0] fsel_flat
);

    typedef struct packed {
        logic [NUM_PINS-1:0][FN_W-1:0] fld;
    } fsel_st_t;

    fsel_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_data = '0;
        for (int p = 0; p < int'(NUM_PINS); p++) begin
            if (word == WIDX_W'(p / PINS_PER_FSEL)) begin
                rd_data[(p % PINS_PER_FSEL)*FN_W +: FN_W] = st_q.fld[p];
                if (wr_en)
                    st_d.fld[p] = wr_data[(p % PINS_PER_FSEL)*FN_W +: FN_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fsel_flat = st_q.fld;

    AST_FSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fsel_flat)); // R10

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pf_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned BANKS    = 2,
    parameter int unsigned BIDX_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [BIDX_W-1:0]   bank,
    input  logic [BUS_W-1:0]    wr_data,
    output logic [NUM_PINS-1:0] lat
);

    localparam int unsigned PAD_W = BANKS * BUS_W;
    localparam logic [PAD_W-1:0] VALID = PAD_W'({NUM_PINS{1'b1}});

    typedef struct packed {
        logic [NUM_PINS-1:0] lat;
    } lat_st_t;

    lat_st_t          st_d, st_q;
    logic [PAD_W-1:0] set_vec, clr_vec, lat_pad;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int b = 0; b < int'(BANKS); b++) begin
            if (bank == BIDX_W'(b)) begin
                if (set_en) set_vec[b*BUS_W +: BUS_W] = wr_data;
                if (clr_en) clr_vec[b*BUS_W +: BUS_W] = wr_data;
            end
        end
        st_d.lat = (st_q.lat | set_vec[NUM_PINS-1:0]) & ~clr_vec[NUM_PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat     = st_q.lat;
    assign lat_pad = PAD_W'(st_q.lat);

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((lat_pad & $past(set_vec)) == ($past(set_vec) & VALID))); // R3
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((lat_pad & $past(clr_vec)) == '0)); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(lat)); // R10

endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
    parameter int unsigned NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] level
);

    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] lvl;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = pad_in;
        st_d.lvl  = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> level == $past(pad_in, 2)); // R6

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
    import gpio_pf_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54
) (
    input  logic [NUM_PINS*FN_W-1:0] fsel_flat,
    output logic [NUM_PINS-1:0]      pad_oe,
    output logic [NUM_PINS-1:0]      alt_en,
    output logic [NUM_PINS*FN_W-1:0] alt_idx
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        alt_sel_t sel;
        assign sel                    = decode_alt(fsel_flat[p*FN_W +: FN_W]);
        assign pad_oe[p]              = (fsel_flat[p*FN_W +: FN_W] == FN_OUTPUT);
        assign alt_en[p]              = sel.en;
        assign alt_idx[p*FN_W +: FN_W] = sel.idx;
    end

endmodule

// File: rtl/gpio_pinfunc_bank.sv
module gpio_pinfunc_bank
    import gpio_pf_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]      pad_in,
    output logic [NUM_PINS-1:0]      pad_oe,
    output logic [NUM_PINS-1:0]      pad_out,
    output logic [NUM_PINS-1:0]      alt_en,
    output logic [NUM_PINS*3-1:0]    alt_idx
);

    localparam int unsigned WIDX_W     = ADDR_W - 2;
    localparam int unsigned BANKS      = (NUM_PINS + BUS_W - 1) / BUS_W;
    localparam int unsigned BIDX_W     = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int unsigned FSEL_WORDS = (NUM_PINS + PINS_PER_FSEL - 1) / PINS_PER_FSEL;
    localparam int unsigned PAD_W      = BANKS * BUS_W;

    localparam logic [WIDX_W-1:0] W_FSEL_END = WIDX_W'(FSEL_WORDS);
    localparam logic [WIDX_W-1:0] W_SET      = WIDX_W'(SET_WORD);
    localparam logic [WIDX_W-1:0] W_CLR      = WIDX_W'(CLR_WORD);
    localparam logic [WIDX_W-1:0] W_LVL      = WIDX_W'(LVL_WORD);
    localparam logic [WIDX_W-1:0] W_BANKS    = WIDX_W'(BANKS);

    logic [WIDX_W-1:0]        word, set_off, clr_off, lvl_off;
    logic                     fsel_hit, set_hit, clr_hit, lvl_hit;
    logic [BIDX_W-1:0]        lat_bank;
    logic [BUS_W-1:0]         fsel_rd, lvl_rd;
    logic [NUM_PINS*FN_W-1:0] fsel_flat;
    logic [NUM_PINS-1:0]      level;
    logic [PAD_W-1:0]         level_pad;

    assign word     = bus_addr[ADDR_W-1:2];
    assign set_off  = word - W_SET;
    assign clr_off  = word - W_CLR;
    assign lvl_off  = word - W_LVL;
    assign fsel_hit = (word < W_FSEL_END);
    assign set_hit  = (word >= W_SET) && (set_off < W_BANKS);
    assign clr_hit  = (word >= W_CLR) && (clr_off < W_BANKS);
    assign lvl_hit  = (word >= W_LVL) && (lvl_off < W_BANKS);
    assign lat_bank = set_hit ? set_off[BIDX_W-1:0] : clr_off[BIDX_W-1:0];

    gpio_fsel_regs #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W)) u_fsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we && fsel_hit),
        .word      (word),
        .wr_data   (bus_wdata),
        .rd_data   (fsel_rd),
        .fsel_flat (fsel_flat)
    );

    gpio_out_latch #(.NUM_PINS(NUM_PINS), .BANKS(BANKS), .BIDX_W(BIDX_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (bus_we && set_hit),
        .clr_en  (bus_we && clr_hit),
        .bank    (lat_bank),
        .wr_data (bus_wdata),
        .lat     (pad_out)
    );

    gpio_level_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level)
    );

    gpio_pad_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .fsel_flat (fsel_flat),
        .pad_oe    (pad_oe),
        .alt_en    (alt_en),
        .alt_idx   (alt_idx)
    );

    assign level_pad = PAD_W'(level);

    always_comb begin
        lvl_rd = '0;
        for (int b = 0; b < int'(BANKS); b++)
            if (lvl_off == WIDX_W'(b)) lvl_rd = level_pad[b*BUS_W +: BUS_W];
    end

    always_comb begin
        if (fsel_hit)     bus_rdata = fsel_rd;
        else if (lvl_hit) bus_rdata = lvl_rd;
        else              bus_rdata = '0;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fsel_hit |-> (bus_rdata[31:30] == 2'b00)); // R2
    AST_WRITE_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit || clr_hit) |-> (bus_rdata == '0)); // R5
    AST_OE_ALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & alt_en) == '0)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (pad_out == '0 && pad_oe == '0 && alt_en == '0)); // R9

endmodule

// File: tb/gpio_pinfunc_bank_test.sv
module gpio_pinfunc_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe, pad_out, alt_en;
    logic [NP*3-1:0] alt_idx;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_rd;

    logic [2:0]    m_fsel [NP];
    logic [NP-1:0] m_lat, m_s1, m_s2;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pinfunc_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .alt_en(alt_en), .alt_idx(alt_idx)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int w = int'(a >> 2);
        logic [31:0] r = '0;
        if (w < 6) begin
            for (int s = 0; s < 10; s++)
                if (w*10 + s < NP) r[s*3 +: 3] = m_fsel[w*10 + s];
        end else if (w == 13) r = m_s2[31:0];
        else if (w == 14)     r = {10'b0, m_s2[NP-1:32]};
        return r;
    endfunction

    function automatic int alt_of(input logic [2:0] c);
        case (c)
            3'd4: return 0; 3'd5: return 1; 3'd6: return 2;
            3'd7: return 3; 3'd3: return 4; 3'd2: return 5;
            default: return -1;
        endcase
    endfunction

    task automatic compare();
        logic [NP-1:0]   e_oe, e_en;
        logic [NP*3-1:0] e_idx;
        logic [31:0]     e_rd;
        string           tag;
        int              w = int'(bus_addr >> 2);
        e_rd = model_read(bus_addr);
        if (bus_we && (w < 6 || w == 7 || w == 8 || w == 10 || w == 11)) tag = "R11";
        else if (w < 6)              tag = "R1";
        else if (w == 13 || w == 14) tag = "R6";
        else if (w == 7 || w == 8 || w == 10 || w == 11) tag = "R5";
        else                         tag = "R10";
        chk(bus_rdata == e_rd, tag, 64'(bus_rdata), 64'(e_rd));
        for (int p = 0; p < NP; p++) begin
            int a = alt_of(m_fsel[p]);
            e_oe[p]        = (m_fsel[p] == 3'd1);
            e_en[p]        = (a >= 0);
            e_idx[p*3 +: 3] = (a >= 0) ? 3'(a) : 3'd0;
        end
        chk(pad_oe == e_oe, "R7", 64'(pad_oe), 64'(e_oe));
        chk(alt_en == e_en, "R8", 64'(alt_en), 64'(e_en));
        chk(alt_idx == e_idx, "R8 idx", 64'(alt_idx), 64'(e_idx));
        chk(pad_out == m_lat, "R3 R4 latch", 64'(pad_out), 64'(m_lat));
    endtask

    task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d);
        int w;
        bus_addr = a; bus_we = we; bus_wdata = d;
        #1;
        last_rd = bus_rdata;
        compare();
        @(posedge clk);
        w = int'(a >> 2);
        if (we) begin
            if (w < 6) begin
                for (int s = 0; s < 10; s++)
                    if (w*10 + s < NP) m_fsel[w*10 + s] = d[s*3 +: 3];
            end
            for (int b = 0; b < 32; b++) begin
                int p0 = b, p1 = 32 + b;
                if (w == 7  && d[b])            m_lat[p0] = 1'b1;
                if (w == 8  && d[b] && p1 < NP) m_lat[p1] = 1'b1;
                if (w == 10 && d[b])            m_lat[p0] = 1'b0;
                if (w == 11 && d[b] && p1 < NP) m_lat[p1] = 1'b0;
            end
        end
        m_s2 = m_s1;
        m_s1 = pad_in;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] pat;
        for (int p = 0; p < NP; p++) m_fsel[p] = 3'd0;
        m_lat = '0; m_s1 = '0; m_s2 = '0;
        repeat (3) @(negedge clk);
        // R9: reset state seen at the ports
        chk(pad_oe == '0 && pad_out == '0 && alt_en == '0, "R9", 64'(pad_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        step(8'h00, 1'b0, 0);
        chk(last_rd == 32'h0, "R9 fsel", 64'(last_rd), 64'd0);

        // R1/R7/R8: pins 0..7 get codes 0..7, pins 8 and 9 code 1
        pat = '0;
        for (int s = 0; s < 8; s++) pat[s*3 +: 3] = 3'(s);
        pat[24 +: 3] = 3'd1; pat[27 +: 3] = 3'd1;
        step(8'h00, 1'b1, pat);
        step(8'h00, 1'b0, 0);
        chk(last_rd == pat, "R1", 64'(last_rd), 64'(pat));
        chk(pad_oe[9:0] == 10'h302, "R7", 64'(pad_oe[9:0]), 64'h302);
        chk(alt_en[9:0] == 10'h0FC, "R8", 64'(alt_en[9:0]), 64'h0FC);
        chk(alt_idx[23:6] == {3'd3, 3'd2, 3'd1, 3'd0, 3'd4, 3'd5}, "R8 order",
            64'(alt_idx[23:6]), 64'({3'd3, 3'd2, 3'd1, 3'd0, 3'd4, 3'd5}));

        // R2: reserved bits and missing pins
        step(8'h04, 1'b1, 32'hFFFF_FFFF);
        step(8'h04, 1'b0, 0);
        chk(last_rd == 32'h3FFF_FFFF, "R2", 64'(last_rd), 64'h3FFF_FFFF);
        step(8'h14, 1'b1, 32'hFFFF_FFFF);
        step(8'h14, 1'b0, 0);
        chk(last_rd == 32'h0000_0FFF, "R2 last", 64'(last_rd), 64'h0FFF);

        // R3/R4/R5: set and clear, zero bits leave latches alone
        step(8'h1C, 1'b1, 32'hA5A5_A5A5);
        chk(pad_out[31:0] == 32'hA5A5_A5A5, "R3", 64'(pad_out[31:0]), 64'hA5A5_A5A5);
        step(8'h20, 1'b1, 32'hFFFF_FFFF);
        chk(pad_out[53:32] == 22'h3F_FFFF, "R3 bank1", 64'(pad_out[53:32]), 64'h3F_FFFF);
        step(8'h1C, 1'b0, 0);
        chk(last_rd == 32'h0, "R5", 64'(last_rd), 64'd0);
        step(8'h28, 1'b1, 32'h0000_FFFF);
        chk(pad_out[31:0] == 32'hA5A5_0000, "R4", 64'(pad_out[31:0]), 64'hA5A5_0000);
        step(8'h1C, 1'b1, 32'h0);
        chk(pad_out[31:0] == 32'hA5A5_0000, "R3 zero", 64'(pad_out[31:0]), 64'hA5A5_0000);
        step(8'h2C, 1'b1, 32'h1);
        chk(pad_out[53:32] == 22'h3F_FFFE, "R4 bank1", 64'(pad_out[53:32]), 64'h3F_FFFE);

        // R10: unmapped and read-only addresses
        step(8'h18, 1'b1, 32'hFFFF_FFFF);
        step(8'h24, 1'b1, 32'hFFFF_FFFF);
        step(8'h34, 1'b1, 32'hFFFF_FFFF);
        step(8'h3C, 1'b1, 32'hFFFF_FFFF);
        chk(pad_out[31:0] == 32'hA5A5_0000, "R10", 64'(pad_out[31:0]), 64'hA5A5_0000);
        step(8'h18, 1'b0, 0);
        chk(last_rd == 32'h0, "R10 read", 64'(last_rd), 64'd0);

        // R11: write and read of one address in one cycle
        step(8'h08, 1'b1, 32'h0000_0008);
        chk(last_rd == 32'h0, "R11 old", 64'(last_rd), 64'd0);
        step(8'h08, 1'b0, 0);
        chk(last_rd == 32'h8, "R11 new", 64'(last_rd), 64'h8);

        // R6: two-edge latency on the level registers
        pad_in = {22'h3F_FFFF, 32'hDEAD_BEEF};
        step(8'h34, 1'b0, 0);
        step(8'h34, 1'b0, 0);
        chk(last_rd == 32'h0, "R6 early", 64'(last_rd), 64'd0);
        step(8'h34, 1'b0, 0);
        chk(last_rd == 32'hDEAD_BEEF, "R6", 64'(last_rd), 64'hDEAD_BEEF);
        step(8'h38, 1'b0, 0);
        chk(last_rd == 32'h003F_FFFF, "R6 bank1", 64'(last_rd), 64'h003F_FFFF);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a = 8'(($urandom % 16) * 4);
            if (i % 3 == 0) pad_in = NP'({$urandom, $urandom});
            step(a, 1'($urandom % 2), $urandom);
        end

        report();
        $finish;
    end

endmodule